// File: doc/BRIEF.md
# Colour Palette Lookup with Format Conversion

This block holds a colour palette of 256 logical entries, stored two to a word in a 128-word by 32-bit memory. Each 16-bit entry carries three 5-bit colour channels plus one flag bit that plays no part in the lookup. A host port writes raw words and can read them back unchanged.

A pixel path takes an 8-bit colour index. It picks the entry, widens each channel to 8 bits, and returns the colour repacked into one of four output encodings that a 2-bit select chooses per lookup. The result is registered, so it appears one clock after the index. A display pipeline sits in front of the block to unpack pixels from fetched frame data. Behind it sits a frame store or scan-out stage that consumes the repacked colour.

The active-low reset input is asynchronous. Inside the block it is released through a two-stage synchroniser, so the block leaves reset on the second rising clock edge after the input goes high.

Top module: `pal_color_lut`

## Requirements
- R1: While reset is held, and after it is released until the first lookup or host read, `col_valid`, `col_out` and `host_rdata` are all zero.
- R2: Pixel index n selects memory word n>>1. An even index uses bits [15:0] of that word and an odd index uses bits [31:16].
- R3: Inside a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 has no effect on any lookup result.
- R4: Each 5-bit channel becomes an 8-bit channel by appending three zero bits below it.
- R5: With `fmt_sel`=0, `col_out` is {24'b0, R8[7:5], G8[7:5], B8[7:6]}.
- R6: With `fmt_sel`=1, `col_out` is {17'b0, R8[7:3], G8[7:3], B8[7:3]}.
- R7: With `fmt_sel`=2, `col_out` is {16'b0, R8[7:3], G8[7:2], B8[7:3]}.
- R8: With `fmt_sel`=3, `col_out` is {8'h00, R8, G8, B8}, with red in bits [23:16] and blue in bits [7:0].
- R9: `col_valid` is high exactly in the cycle after one in which `pix_valid` was high. `col_out` holds its value when `pix_valid` was low. Back-to-back lookups give one result per cycle.
- R10: A host write changes lookups presented from the next cycle on. A lookup presented in the same cycle as a write to its word returns the old contents.
- R11: One cycle after `host_re`, `host_rdata` holds the raw 32-bit word at `host_raddr` as written, flag bits included. Without `host_re`, `host_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 7 | Host write word address |
| host_wdata | input | 32 | Host write data, two raw entries |
| host_re | input | 1 | Host read strobe |
| host_raddr | input | 7 | Host read word address |
| host_rdata | output | 32 | Registered raw read-back word |
| pix_valid | input | 1 | Lookup request |
| pix_index | input | 8 | Palette index for the lookup |
| fmt_sel | input | 2 | Output encoding: 0 8-bit, 1 15-bit, 2 16-bit, 3 24/32-bit |
| col_valid | output | 1 | Lookup result valid |
| col_out | output | 32 | Repacked colour, zero-extended |

## Verification
Every result in this block is due exactly one rising edge after its stimulus: the lookup colour and its valid flag after `pix_valid`, and the read-back word after `host_re`. A write becomes visible to lookups presented one edge after it. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, half a period after the edge that registered them. This gives each lookup and read its own expected value, with no cycle drift. The same-cycle write-and-lookup case and the hold case are checked at that same sampling point, against the old word and the previous output respectively.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int PAL_WORDS  = 128;
  localparam int PAL_WORD_W = 32;
  localparam int ENTRY_W    = 16;
  localparam int CH_IN_W    = 5;
  localparam int CH_OUT_W   = 8;
  localparam int COL_W      = 32;

  typedef enum logic [1:0] {
    FMT_RGB332 = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_RGB888 = 2'd3
  } pal_fmt_e;

  typedef struct packed {
    logic [CH_OUT_W-1:0] red;
    logic [CH_OUT_W-1:0] grn;
    logic [CH_OUT_W-1:0] blu;
  } rgb_wide_t;

endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     lk_addr,
  output logic [WORD_W-1:0] lk_data,
  input  logic              rb_en,
  input  logic [AW-1:0]     rb_addr,
  output logic [WORD_W-1:0] rb_data
);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] rb_q;
  logic [WORD_W-1:0] rb_d;

  // Storage array: no reset, written under its enable.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Lookup side reads the array combinationally; the caller registers it.
  assign lk_data = mem[lk_addr];

  always_comb begin
    rb_d = rb_q;
    if (rb_en) begin
      rb_d = mem[rb_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q <= '0;
    end else begin
      rb_q <= rb_d;
    end
  end

  assign rb_data = rb_q;

endmodule

// File: rtl/pal_expand.sv
module pal_expand
  import pal_pkg::*;
#(
  parameter int WORD_W = PAL_WORD_W,
  parameter int EW     = ENTRY_W,
  parameter int CIN    = CH_IN_W,
  parameter int COUT   = CH_OUT_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              hi_half,
  output rgb_wide_t         color
);

  localparam int NCH = 3;
  localparam int PAD = COUT - CIN;

  logic [EW-1:0]   entry;
  logic [COUT-1:0] wide [NCH];
  logic            unused_flag;

  assign entry       = hi_half ? word[2*EW-1:EW] : word[EW-1:0];
  assign unused_flag = entry[EW-1];

  // Channel c sits at bits [c*CIN +: CIN]: 0 red, 1 green, 2 blue.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wide[c] = {entry[c*CIN +: CIN], {PAD{1'b0}}};
  end

  assign color.red = wide[0];
  assign color.grn = wide[1];
  assign color.blu = wide[2];

endmodule

// File: rtl/pal_pack.sv
module pal_pack
  import pal_pkg::*;
#(
  parameter int OW = COL_W
) (
  input  rgb_wide_t     color,
  input  pal_fmt_e      fmt,
  output logic [OW-1:0] packed_col
);

  logic [7:0]  p8;
  logic [14:0] p15;
  logic [15:0] p16;
  logic [23:0] p24;

  assign p8  = {color.red[7:5], color.grn[7:5], color.blu[7:6]};
  assign p15 = {color.red[7:3], color.grn[7:3], color.blu[7:3]};
  assign p16 = {color.red[7:3], color.grn[7:2], color.blu[7:3]};
  assign p24 = {color.red, color.grn, color.blu};

  always_comb begin
    packed_col = '0;
    unique case (fmt)
      FMT_RGB332: packed_col[7:0]  = p8;
      FMT_RGB555: packed_col[14:0] = p15;
      FMT_RGB565: packed_col[15:0] = p16;
      FMT_RGB888: packed_col[23:0] = p24;
      default:    packed_col       = '0;
    endcase
  end

endmodule

// File: rtl/pal_color_lut.sv
module pal_color_lut
  import pal_pkg::*;
#(
  parameter int WORDS   = PAL_WORDS,
  parameter int WORD_W  = PAL_WORD_W,
  parameter int OUT_W   = COL_W,
  parameter int SYNC_ST = 2,
  localparam int AW     = $clog2(WORDS),
  localparam int IW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [AW-1:0]     host_waddr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_re,
  input  logic [AW-1:0]     host_raddr,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              pix_valid,
  input  logic [IW-1:0]     pix_index,
  input  logic [1:0]        fmt_sel,
  output logic              col_valid,
  output logic [OUT_W-1:0]  col_out
);

  logic              rst_sync_n;
  logic [WORD_W-1:0] lk_word;
  rgb_wide_t         lk_rgb;
  logic [OUT_W-1:0]  lk_packed;
  pal_fmt_e          fmt;
  logic              vld_q, vld_d;
  logic [OUT_W-1:0]  col_q, col_d;

  pal_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  pal_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (host_we),
    .wr_addr (host_waddr),
    .wr_data (host_wdata),
    .lk_addr (pix_index[IW-1:1]),
    .lk_data (lk_word),
    .rb_en   (host_re),
    .rb_addr (host_raddr),
    .rb_data (host_rdata)
  );

  pal_expand #(.WORD_W(WORD_W)) u_exp (
    .word    (lk_word),
    .hi_half (pix_index[0]),
    .color   (lk_rgb)
  );

  assign fmt = pal_fmt_e'(fmt_sel);

  pal_pack #(.OW(OUT_W)) u_pack (
    .color      (lk_rgb),
    .fmt        (fmt),
    .packed_col (lk_packed)
  );

  // Output stage: next-state logic with an explicit enable.
  always_comb begin
    vld_d = pix_valid;
    col_d = col_q;
    if (pix_valid) begin
      col_d = lk_packed;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      col_q <= '0;
    end else begin
      vld_q <= vld_d;
      col_q <= col_d;
    end
  end

  assign col_valid = vld_q;
  assign col_out   = col_q;

endmodule

// File: rtl/pal_color_lut_chk.sv
module pal_color_lut_chk #(
  parameter int WORD_W = 32,
  parameter int OUT_W  = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              pix_valid,
  input logic [1:0]        fmt_sel,
  input logic              col_valid,
  input logic [OUT_W-1:0]  col_out,
  input logic              host_re,
  input logic [WORD_W-1:0] host_rdata
);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pix_valid |=> col_valid);

  a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pix_valid |=> !col_valid);

  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pix_valid |=> $stable(col_out));

  a_r5_narrow_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_valid && fmt_sel == 2'd0) |=> (col_out[OUT_W-1:8] == '0));

  a_r6_fifteen_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_valid && fmt_sel == 2'd1) |=> (col_out[OUT_W-1:15] == '0));

  // R7 with R4: green bit 2 of the widened channel is always zero.
  a_r7_sixteen_shape: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_valid && fmt_sel == 2'd2) |=> (col_out[OUT_W-1:16] == '0 && col_out[5] == 1'b0));

  // R8 with R4: top byte clear and low three bits of each channel clear.
  a_r8_wide_shape: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pix_valid && fmt_sel == 2'd3) |=>
      (col_out[OUT_W-1:24] == '0 && col_out[18:16] == 3'b0 &&
       col_out[10:8] == 3'b0 && col_out[2:0] == 3'b0));

  a_r11_readback_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_re |=> $stable(host_rdata));

endmodule

bind pal_color_lut pal_color_lut_chk #(.WORD_W(WORD_W), .OUT_W(OUT_W)) i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pix_valid  (pix_valid),
  .fmt_sel    (fmt_sel),
  .col_valid  (col_valid),
  .col_out    (col_out),
  .host_re    (host_re),
  .host_rdata (host_rdata)
);

// File: tb/test_pal_color_lut.sv
module test_pal_color_lut;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [6:0]  host_waddr;
  logic [31:0] host_wdata;
  logic        host_re;
  logic [6:0]  host_raddr;
  logic [31:0] host_rdata;
  logic        pix_valid;
  logic [7:0]  pix_index;
  logic [1:0]  fmt_sel;
  logic        col_valid;
  logic [31:0] col_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] shadow [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_color_lut i_pal_color_lut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_re(host_re), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .pix_valid(pix_valid), .pix_index(pix_index), .fmt_sel(fmt_sel),
    .col_valid(col_valid), .col_out(col_out)
  );

  function automatic logic [31:0] exp_col(input logic [31:0] w, input logic odd,
                                          input logic [1:0] f);
    logic [15:0] e;
    logic [7:0] r, g, b;
    e = odd ? w[31:16] : w[15:0];
    r = {e[4:0], 3'b000};
    g = {e[9:5], 3'b000};
    b = {e[14:10], 3'b000};
    case (f)
      2'd0:    return {24'b0, r[7:5], g[7:5], b[7:6]};
      2'd1:    return {17'b0, r[7:3], g[7:3], b[7:3]};
      2'd2:    return {16'b0, r[7:3], g[7:2], b[7:3]};
      default: return {8'h00, r, g, b};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    tick();
    host_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic rd(input logic [6:0] a, input string req);
    host_re = 1'b1; host_raddr = a;
    tick();
    host_re = 1'b0;
    check(req, host_rdata, shadow[a]);
  endtask

  task automatic look(input logic [7:0] idx, input logic [1:0] f, input string req);
    pix_valid = 1'b1; pix_index = idx; fmt_sel = f;
    tick();
    pix_valid = 1'b0;
    check({req, " valid"}, {31'b0, col_valid}, 32'd1);
    check(req, col_out, exp_col(shadow[idx[7:1]], idx[0], f));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_val;
    logic [31:0] prev;
    logic [31:0] oldw;
    seed_val = $urandom(32'd4242);
    rst_n = 1'b0; host_we = 1'b0; host_waddr = '0; host_wdata = '0;
    host_re = 1'b0; host_raddr = '0; pix_valid = 1'b0; pix_index = '0; fmt_sel = '0;
    repeat (3) tick();
    // R1: outputs clear in reset and after release
    check("R1 col_valid in reset", {31'b0, col_valid}, 32'd0);
    check("R1 col_out in reset", col_out, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 col_valid after release", {31'b0, col_valid}, 32'd0);
    check("R1 col_out after release", col_out, 32'd0);
    check("R1 host_rdata after release", host_rdata, 32'd0);

    for (int i = 0; i < 128; i++) wr(i[6:0], $urandom);

    // R11 raw read-back, flag bits included
    wr(7'd3, 32'hFFFF_FFFF);
    rd(7'd3, "R11 all ones");
    wr(7'd4, 32'h8000_8000);
    rd(7'd4, "R11 flags only");
    rd(7'd77, "R11 random word");
    host_raddr = 7'd3;
    tick();
    check("R11 hold without read", host_rdata, shadow[7'd77]);

    // R3 flag bit ignored: flags-only word gives zero colour
    for (int f = 0; f < 4; f++) begin
      look(8'd8, f[1:0], "R3 even flag ignored");
      look(8'd9, f[1:0], "R3 odd flag ignored");
    end
    // R2 even/odd halves with distinct entries
    wr(7'd10, 32'h001F_7C00);
    look(8'd20, 2'd3, "R2 even half blue");
    look(8'd21, 2'd3, "R2 odd half red");
    // R4/R8 full-scale channels
    look(8'd6, 2'd3, "R8 all ones wide");
    look(8'd7, 2'd3, "R4 all ones expanded");
    wr(7'd11, 32'h03E0_0421);
    for (int f = 0; f < 4; f++) begin
      look(8'd22, f[1:0], "R5 R6 R7 R8 low ones");
      look(8'd23, f[1:0], "R5 R6 R7 R8 green only");
    end
    look(8'd6, 2'd0, "R5 all ones narrow");
    look(8'd6, 2'd1, "R6 all ones fifteen");
    look(8'd6, 2'd2, "R7 all ones sixteen");

    // R9 back-to-back lookups
    for (int i = 0; i < 16; i++) begin
      pix_valid = 1'b1; pix_index = 8'($urandom); fmt_sel = 2'($urandom);
      tick();
      check("R9 burst valid", {31'b0, col_valid}, 32'd1);
      check("R9 burst data", col_out, exp_col(shadow[pix_index[7:1]], pix_index[0], fmt_sel));
    end
    pix_valid = 1'b0;
    prev = col_out;
    pix_index = 8'd6; fmt_sel = 2'd3;
    tick();
    check("R9 valid drops", {31'b0, col_valid}, 32'd0);
    check("R9 output holds", col_out, prev);

    // R10 same-cycle write and lookup
    oldw = shadow[7'd30];
    host_we = 1'b1; host_waddr = 7'd30; host_wdata = ~oldw;
    pix_valid = 1'b1; pix_index = 8'd60; fmt_sel = 2'd3;
    tick();
    host_we = 1'b0; pix_valid = 1'b0;
    check("R10 same cycle sees old", col_out, exp_col(oldw, 1'b0, 2'd3));
    shadow[7'd30] = ~oldw;
    look(8'd60, 2'd3, "R10 next cycle even");
    look(8'd61, 2'd2, "R10 next cycle odd");

    // Random mix of writes, reads and lookups
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) wr(7'($urandom), $urandom);
      else if (r == 1) rd(7'($urandom), "R11 random read");
      else look(8'($urandom), 2'($urandom), "R2 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule